// File: doc/BRIEF.md
# Byte-Sliced Sequential Multiplier

This block multiplies two unsigned 16-bit operands using a single 8x8 unsigned multiplier core. The core is reused over several clock cycles. In each busy cycle the block picks one pair of operand bytes and forms their 16-bit sub-product. It then moves that sub-product to its weight (no shift, 8 or 16 bits) and adds it into a 32-bit accumulator. The core sums eight AND-masked partial products, each shifted left by its bit index.

The block can return the whole 32-bit product or only its low 16 bits. In low-half mode the high-byte-by-high-byte term cannot affect bits [15:0], so the block skips it and finishes one cycle sooner. A caller raises `start` with the operands and the mode. It then waits for the one-cycle `done` pulse and reads `product`.

Top module: `chunk_mul16`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: When `start` is 1 and `busy` is 0 at a clock edge, the block captures `u_in`, `v_in` and `low_only` on that edge and shows `busy`=1 from that edge on.
- R3: With `low_only`=0 captured, `done` rises on the 4th clock edge after the accepting edge, and `product` equals `u_in*v_in` as a 32-bit unsigned value.
- R4: With `low_only`=1 captured, `done` rises on the 3rd clock edge after the accepting edge, and `product[15:0]` equals `(u_in*v_in) mod 65536`.
- R5: While the captured mode is `low_only`=1, `product[31:16]` is 0 whenever `busy` is 0.
- R6: `done` is high for exactly one cycle, and `busy` is 0 in that cycle.
- R7: A `start` that arrives while `busy` is 1 is ignored. The operands, the mode, the result and the `done` timing of the running operation do not change.
- R8: After `done`, `product` keeps its value until the next accepted `start`.
- R9: No carry is lost. With both operands at 0xFFFF in full mode, the result is 0xFFFE0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new multiplication |
| low_only | input | 1 | 1 = only bits [15:0] are wanted, 0 = full product |
| u_in | input | 16 | First operand |
| v_in | input | 16 | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result ready |
| product | output | 32 | Result; upper half is zero in low-half mode |

## Verification
A wrong step counter shows up at `busy` and `done` on the first edge where the sequence should end. It appears within four cycles of `start`, because a step that is skipped or repeated moves the `done` pulse. A wrong byte selection, a wrong shift or a lost carry in the accumulator corrupts `product` in the `done` cycle. Operands with distinct bytes in every position expose each of these faults. A start accepted while busy changes the captured operands, and the next result shows it. All of these are caught on the cycle they occur, by comparison against a per-clock reference model.

// File: rtl/chunk_mul16.sv
module chunk_mul16 #(
  parameter int OPW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             low_only,
  input  logic [OPW-1:0]   u_in,
  input  logic [OPW-1:0]   v_in,
  output logic             busy,
  output logic             done,
  output logic [2*OPW-1:0] product
);
  localparam int HW = OPW / 2;
  localparam int PW = 2 * OPW;

  logic [OPW-1:0] u_q, v_q;
  logic           low_q, busy_q, done_q;
  logic [1:0]     step_q;
  logic [PW-1:0]  acc_q;

  logic [HW-1:0]  a_sel, b_sel;
  logic [HW-1:0]  pp [HW];
  logic [OPW-1:0] core_sum;
  logic [PW-1:0]  placed;
  logic           last_step;
  logic           accept;

  assign accept    = start && !busy_q;
  assign last_step = low_q ? (step_q == 2'd2) : (step_q == 2'd3);

  // step order: lo*lo, hi(u)*lo(v), lo(u)*hi(v), hi*hi
  assign a_sel = step_q[0] ? u_q[OPW-1:HW] : u_q[HW-1:0];
  assign b_sel = step_q[1] ? v_q[OPW-1:HW] : v_q[HW-1:0];

  for (genvar i = 0; i < HW; i++) begin : g_pp
    assign pp[i] = {HW{a_sel[i]}} & b_sel;
  end

  always_comb begin
    core_sum = '0;
    for (int i = 0; i < HW; i++)
      core_sum = core_sum + (OPW'(pp[i]) << i);
  end

  always_comb begin
    case (step_q)
      2'd0:    placed = PW'(core_sum);
      2'd3:    placed = PW'(core_sum) << OPW;
      default: placed = PW'(core_sum) << HW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u_q    <= '0;
      v_q    <= '0;
      low_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      acc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        u_q    <= u_in;
        v_q    <= v_in;
        low_q  <= low_only;
        busy_q <= 1'b1;
        step_q <= '0;
        acc_q  <= '0;
      end else if (busy_q) begin
        acc_q  <= acc_q + placed;
        step_q <= step_q + 2'd1;
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = low_q ? {{OPW{1'b0}}, acc_q[OPW-1:0]} : acc_q;

  a_r2_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && acc_q == '0 && step_q == 2'd0));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r7_hold_operands: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(u_q) && $stable(v_q) && $stable(low_q)));

  a_r4_low_three_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && low_q) |-> (step_q <= 2'd2));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (acc_q >= $past(acc_q)));

  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

// File: tb/chunk_mul16_tb.sv
module chunk_mul16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        low_only = 1'b0;
  logic [15:0] u_in = '0, v_in = '0;
  logic        busy, done;
  logic [31:0] product;

  int n_tests = 0, n_fail = 0, cycles = 0;
  string tag = "R3";

  // reference model state
  bit          m_busy = 0, m_done = 0, m_have = 0, m_low = 0;
  int          m_left = 0;
  logic [31:0] m_exp = '0;

  always #5 clk = ~clk;

  chunk_mul16 dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .low_only(low_only),
    .u_in(u_in), .v_in(v_in), .busy(busy), .done(done), .product(product)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      m_done = 0;
      if (start && !m_busy) begin
        longint unsigned full;
        full   = longint'(u_in) * longint'(v_in);
        m_busy = 1;
        m_low  = low_only;
        m_left = low_only ? 3 : 4;
        m_exp  = low_only ? (32'(full) & 32'h0000_FFFF) : 32'(full);
        m_have = 0;
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          m_done = 1;
          m_have = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 busy", 32'(busy), 32'(m_busy));
      check(m_low ? "R4 done" : "R3 done", 32'(done), 32'(m_done));
      if (m_done) begin
        check(tag, product, m_exp);
        if (m_low) check("R5 upper zero", 32'(product[31:16]), 32'h0);
        check("R6 done idle", 32'(busy), 32'h0);
      end else if (m_have && !m_busy) begin
        check("R8 result held", product, m_exp);
      end
    end
  end

  task automatic op(input logic [15:0] u, input logic [15:0] v, input bit low, input string t);
    @(negedge clk);
    tag = t; u_in = u; v_in = v; low_only = low; start = 1'b1;
    @(negedge clk);
    start = 1'b0; u_in = 16'h0; v_in = 16'h0;
    wait (done === 1'b1);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cycles > 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy), 32'h0);
    check("R1 done", 32'(done), 32'h0);
    check("R1 product", product, 32'h0);
    rst_n = 1'b1;

    op(16'h1234, 16'h5678, 1'b0, "R3 full product");
    op(16'hA5C3, 16'h3C5A, 1'b0, "R3 full product");
    op(16'h00FF, 16'hFF00, 1'b0, "R3 full product");
    op(16'h0000, 16'hBEEF, 1'b0, "R3 full product");
    op(16'hFFFF, 16'hFFFF, 1'b0, "R9 max carry");
    op(16'hFFFF, 16'hFFFF, 1'b1, "R4 low product");
    op(16'h1234, 16'h5678, 1'b1, "R4 low product");
    op(16'hF00D, 16'h8001, 1'b1, "R4 low product");

    // R7: second start during busy with different operands and mode
    @(negedge clk);
    tag = "R7 ignored start"; u_in = 16'h0103; v_in = 16'h0507; low_only = 1'b0; start = 1'b1;
    @(negedge clk);
    u_in = 16'hFFFF; v_in = 16'hEEEE; low_only = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0; u_in = 16'h0; v_in = 16'h0; low_only = 1'b0;
    wait (done === 1'b1);
    repeat (5) @(negedge clk);

    // back-to-back: start in the done cycle
    @(negedge clk);
    tag = "R3 full product"; u_in = 16'h8000; v_in = 16'h0002; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (done === 1'b1);
    @(negedge clk);
    // done is high in this cycle; restart now
    tag = "R4 low product"; u_in = 16'h7FFF; v_in = 16'h0003; low_only = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; low_only = 1'b0;
    wait (done === 1'b1);
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule